// File: doc/BRIEF.md
# I2C 10-bit Address Acknowledge Poller

This block is a small I2C bus master that keeps probing one slave with a 10-bit address until the slave answers. Each probe is an address-only transaction. It is a START, then the two 10-bit address bytes with the direction bit set to write, then a STOP. No data byte is moved in either direction. A common use is to wait for a serial EEPROM to finish its internal write cycle. While that cycle runs the memory refuses its address, and it acknowledges again once the cycle is complete.

A one-cycle `start` pulse latches the target address, the retry limit and the clock divider. The block then drives the open-drain lines through active-high pull-down enables and samples the real line levels. A NACK on either address byte ends the attempt with a STOP. The bus then rests for at least one bit period, and the next attempt begins. Polling ends when both bytes are acknowledged, or when the retry limit is used up. At that point `done` pulses and either `acked` or `timeout` is left standing.

Top module: `i2c_ack_poller`

## Requirements
- R1: After reset both pull-down enables are 0 (lines released), and `busy`, `done`, `acked` and `timeout` are 0.
- R2: `start` is accepted only while `busy` is 0. `busy` is 1 from the next cycle until polling ends. A `start` pulse while busy has no effect on the address sent or on the number of attempts.
- R3: The first byte on the bus is 1,1,1,1,0,A9,A8,0, MSB first, with the last bit 0 meaning write. The second byte is A7 down to A0, MSB first. An acknowledged attempt carries exactly these two bytes and no data byte.
- R4: With no clock stretching, each quarter of a bit lasts `clk_div`+1 clock cycles. SCL rising edges inside a byte are therefore 4*(`clk_div`+1) cycles apart.
- R5: Every attempt opens with a START (SDA falls while SCL is high) and closes with a STOP (SDA rises while SCL is high). At all other times SDA changes only while SCL is low.
- R6: A NACK (SDA high in the ninth clock) after the first byte skips the second byte, and the STOP follows at once.
- R7: A NACK on either byte starts a new attempt without raising `done` or `timeout`. At least 4*(`clk_div`+1) cycles separate that STOP from the next START.
- R8: With a retry limit N greater than 0, polling gives up with `timeout` after N unacknowledged attempts. A limit of 0 retries without bound.
- R9: `done` is a single-cycle pulse in the cycle `busy` falls. `acked` or `timeout` (never both) then holds until the next accepted `start`, which clears them.
- R10: After the master releases SCL, the sequencer waits while another device holds SCL low. The bytes and the outcome are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| addr | input | 10 | 10-bit target slave address |
| retry_limit | input | RW | Maximum attempts; 0 means unbounded |
| clk_div | input | DW | Quarter-bit length minus one, in clock cycles |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle pulse when polling ends |
| acked | output | 1 | Slave acknowledged both address bytes |
| timeout | output | 1 | Retry limit used up without acknowledge |

## Verification
The in-RTL properties check the following on every cycle:
- SDA moves under a released SCL only in the START or STOP states.
- The direction bit drives low and the acknowledge slot is released.
- Quarter ticks are spaced by the divider.
- The failure count stays under a nonzero limit.
- `done` is one cycle wide with `busy` low, and `acked` and `timeout` are exclusive.

The bench scenarios, observed through a bus monitor and a slave model, show what no single-cycle property can:
- the exact byte values;
- skipping the second byte after a first-byte NACK;
- the retry count against the limit;
- the idle gap between attempts;
- the SCL bit period;
- survival of clock stretching.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BIT,
    S_STOP,
    S_GAP
  } bus_state_e;

  // header byte of a 10-bit address: 11110, A9, A8, write bit (0)
  function automatic logic [7:0] hdr_byte(input logic [9:0] a);
    return {5'b11110, a[9:8], 1'b0};
  endfunction

  function automatic logic [7:0] low_byte(input logic [9:0] a);
    return a[7:0];
  endfunction

  // true when the attempt just failed reaches a nonzero limit
  function automatic logic limit_hit(input int unsigned fails_next,
                                     input int unsigned lim);
    return (lim != 0) && (fails_next >= lim);
  endfunction

endpackage

// File: rtl/i2cp_qtick.sv
module i2cp_qtick #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4: ticks are never back to back unless the divider is zero
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/i2cp_tries.sv
module i2cp_tries #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  input  logic [RW-1:0] limit,
  output logic          give_up
);
  import i2cp_pkg::*;

  logic [RW-1:0] fails_q;

  assign give_up = limit_hit(32'(fails_q) + 32'd1, 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fails_q <= '0;
    else if (clear)                  fails_q <= '0;
    else if (bump && fails_q != '1)  fails_q <= fails_q + 1'b1;
  end

  // R8: a bounded run never records as many failures as its limit
  p_fail_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && limit != '0) |-> (fails_q < limit));

endmodule

// File: rtl/i2c_ack_poller.sv
module i2c_ack_poller #(
  parameter int RW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [9:0]    addr,
  input  logic [RW-1:0] retry_limit,
  input  logic [DW-1:0] clk_div,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          acked,
  output logic          timeout
);
  import i2cp_pkg::*;

  localparam int BITS_PER_SLOT = 9;
  localparam logic [3:0] ACK_SLOT = 4'(BITS_PER_SLOT - 1);

  bus_state_e    state_q;
  logic [1:0]    phase_q;
  logic [3:0]    bit_q;
  logic          sel_q;
  logic [7:0]    shreg_q;
  logic          scl_low_q, sda_low_q;
  logic          ok_q;
  logic          done_q, acked_q, timeout_q;
  logic [9:0]    addr_q;
  logic [RW-1:0] lim_q;
  logic [DW-1:0] div_q;

  // named internal events
  logic qtick_w, stretch_w, adv_w, accept_w;
  logic ack_slot_end_w, slave_ack_w, gap_end_w, give_up_w, bump_w;

  assign busy      = (state_q != S_IDLE);
  assign accept_w  = (state_q == S_IDLE) && start;
  assign stretch_w = !scl_low_q && !scl_i;
  assign adv_w     = qtick_w && !stretch_w;
  assign ack_slot_end_w = adv_w && state_q == S_BIT && bit_q == ACK_SLOT && phase_q == 2'd3;
  assign slave_ack_w    = !sda_i;
  assign gap_end_w      = adv_w && state_q == S_GAP && phase_q == 2'd3;
  assign bump_w         = gap_end_w && !ok_q && !give_up_w;

  i2cp_qtick #(.DW(DW)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (div_q),
    .tick (qtick_w)
  );

  i2cp_tries #(.RW(RW)) u_tries (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept_w),
    .bump   (bump_w),
    .limit  (lim_q),
    .give_up(give_up_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      phase_q   <= '0;
      bit_q     <= '0;
      sel_q     <= 1'b0;
      shreg_q   <= '0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      ok_q      <= 1'b0;
      done_q    <= 1'b0;
      acked_q   <= 1'b0;
      timeout_q <= 1'b0;
      addr_q    <= '0;
      lim_q     <= '0;
      div_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        state_q   <= S_START;
        phase_q   <= '0;
        acked_q   <= 1'b0;
        timeout_q <= 1'b0;
        addr_q    <= addr;
        lim_q     <= retry_limit;
        div_q     <= clk_div;
      end else if (adv_w) begin
        phase_q <= phase_q + 2'd1;
        case (state_q)
          S_START: begin
            // released, released, SDA low (START), SCL low
            if (phase_q == 2'd1) sda_low_q <= 1'b1;
            if (phase_q == 2'd2) scl_low_q <= 1'b1;
            if (phase_q == 2'd3) begin
              state_q <= S_BIT;
              bit_q   <= '0;
              sel_q   <= 1'b0;
              ok_q    <= 1'b0;
              shreg_q <= hdr_byte(addr_q);
            end
          end
          S_BIT: begin
            // SCL low, SDA set, SCL high, SCL high
            if (phase_q == 2'd0)
              sda_low_q <= (bit_q == ACK_SLOT) ? 1'b0 : !shreg_q[7];
            if (phase_q == 2'd1) scl_low_q <= 1'b0;
            if (phase_q == 2'd3) begin
              scl_low_q <= 1'b1;
              if (bit_q != ACK_SLOT) begin
                bit_q   <= bit_q + 4'd1;
                shreg_q <= {shreg_q[6:0], 1'b0};
              end else if (slave_ack_w && !sel_q) begin
                sel_q   <= 1'b1;
                bit_q   <= '0;
                shreg_q <= low_byte(addr_q);
              end else begin
                ok_q    <= slave_ack_w && sel_q;
                state_q <= S_STOP;
              end
            end
          end
          S_STOP: begin
            // SCL low, SDA low, SCL high, SDA released (STOP)
            if (phase_q == 2'd0) sda_low_q <= 1'b1;
            if (phase_q == 2'd1) scl_low_q <= 1'b0;
            if (phase_q == 2'd2) sda_low_q <= 1'b0;
            if (phase_q == 2'd3) state_q <= S_GAP;
          end
          S_GAP: begin
            if (phase_q == 2'd3) begin
              if (ok_q) begin
                acked_q <= 1'b1;
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end else if (give_up_w) begin
                timeout_q <= 1'b1;
                done_q    <= 1'b1;
                state_q   <= S_IDLE;
              end else begin
                state_q <= S_START;
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign scl_oe  = scl_low_q;
  assign sda_oe  = sda_low_q;
  assign done    = done_q;
  assign acked   = acked_q;
  assign timeout = timeout_q;

  // R1: the lines are released while idle
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> (!scl_oe && !sda_oe));

  // R5: SDA moves under a high SCL only while forming START or STOP
  p_sda_under_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe))
      |-> ($past(state_q) == S_START || $past(state_q) == S_STOP));

  // R3: the direction bit of the header byte is driven low (write)
  p_write_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BIT && !sel_q && bit_q == 4'd7 && phase_q >= 2'd2) |-> sda_oe);

  // R3: SDA is released for the slave during every acknowledge slot
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BIT && bit_q == ACK_SLOT && phase_q != 2'd0) |-> !sda_oe);

  // R9: done is one cycle wide and coincides with busy low
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: the two outcomes exclude each other
  p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acked && timeout));

  // R10: nothing advances while SCL is held low by another device
  p_stretch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stretch_w && !accept_w) |=> $stable(phase_q));

endmodule

// File: tb/i2c_ack_poller_tb.sv
module i2c_ack_poller_tb;
  localparam int RW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [9:0]    addr = '0;
  logic [RW-1:0] retry_limit = '0;
  logic [DW-1:0] clk_div = '0;
  logic          scl_oe, sda_oe, busy, done, acked, timeout;
  logic          stretch = 1'b0;
  logic          slave_pull = 1'b0;
  wire           scl_line = !(scl_oe || stretch);
  wire           sda_line = !(sda_oe || slave_pull);

  int total = 0;
  int bad = 0;

  always #4 clk = !clk;

  i2c_ack_poller #(.RW(RW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
    .retry_limit(retry_limit), .clk_div(clk_div),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .acked(acked), .timeout(timeout)
  );

  // slave model policy
  int  fail_att = 0;
  bit  fail_first = 0;
  bit  stretch_en = 0;

  // monitor records
  int  cyc = 0;
  int  starts = 0, stops = 0, dones = 0;
  int  bitcnt = 0, byte_idx = 0;
  bit  in_ack = 0;
  logic [7:0] shv = '0;
  logic [7:0] b0 = '0, b1 = '0;
  int  min_bytes = 99, max_bytes = 0;
  int  gap_min = 1000000, last_stop = 0;
  int  per_min = 1000000, per_max = 0, last_rise = 0;
  int  hold = 0;
  logic pscl = 1'b1, psda = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done) dones <= dones + 1;
    if (stretch_en && scl_oe) hold <= 10;
    else if (hold > 0) hold <= hold - 1;
    stretch <= stretch_en && (scl_oe || hold > 0);
    if (scl_line && pscl && psda && !sda_line) begin
      starts <= starts + 1;
      if (stops > 0 && cyc - last_stop < gap_min) gap_min <= cyc - last_stop;
      bitcnt <= 0; byte_idx <= 0; in_ack <= 0;
    end else if (scl_line && pscl && !psda && sda_line) begin
      stops <= stops + 1;
      last_stop <= cyc;
      if (byte_idx < min_bytes) min_bytes <= byte_idx;
      if (byte_idx > max_bytes) max_bytes <= byte_idx;
    end else if (scl_line && !pscl) begin
      if (bitcnt >= 1 && bitcnt <= 7) begin
        if (cyc - last_rise < per_min) per_min <= cyc - last_rise;
        if (cyc - last_rise > per_max) per_max <= cyc - last_rise;
      end
      last_rise <= cyc;
      if (!in_ack) begin
        shv <= {shv[6:0], sda_line};
        if (bitcnt == 7) begin
          if (byte_idx == 0) b0 <= {shv[6:0], sda_line};
          else               b1 <= {shv[6:0], sda_line};
        end
        bitcnt <= bitcnt + 1;
      end
    end else if (!scl_line && pscl) begin
      if (bitcnt == 8 && !in_ack) begin
        in_ack <= 1;
        if (byte_idx == 0) slave_pull <= !(fail_first && starts <= fail_att);
        else               slave_pull <= (starts > fail_att);
      end else if (in_ack) begin
        in_ack <= 0; slave_pull <= 0; bitcnt <= 0;
        byte_idx <= byte_idx + 1;
      end
    end
    pscl <= scl_line;
    psda <= sda_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    starts = 0; stops = 0; dones = 0;
    min_bytes = 99; max_bytes = 0; gap_min = 1000000;
    per_min = 1000000; per_max = 0;
  endtask

  task automatic pulse_start(input logic [9:0] a, input int div, input int lim);
    @(posedge clk); #1;
    addr = a; clk_div = DW'(div); retry_limit = RW'(lim); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done && n < 60000) begin @(negedge clk); n++; end
    check(done == 1'b1, "R9 done seen", done, 1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);
    check(!acked && !timeout, "R1 flags low", {acked, timeout}, 0);
  endtask

  task automatic t_first_ack();
    fail_att = 0; fail_first = 0; clear_mon();
    pulse_start(10'h2A5, 2, 0);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    repeat (30) @(negedge clk);
    pulse_start(10'h1FF, 2, 0);  // ignored while busy
    wait_done();
    check(b0 == 8'hF4, "R3 header byte", b0, 8'hF4);
    check(b1 == 8'hA5, "R3 low byte", b1, 8'hA5);
    check(starts == 1 && stops == 1, "R2 R5 one attempt", starts, 1);
    check(max_bytes == 2 && min_bytes == 2, "R3 two bytes only", max_bytes, 2);
    check(per_min == 12 && per_max == 12, "R4 bit period div2", per_min, 12);
    check(acked && !timeout, "R9 acked held", {acked, timeout}, 2);
    check(dones == 1, "R9 done one cycle", dones, 1);
    check(!busy, "R9 busy low", busy, 0);
  endtask

  task automatic t_second_nack_retry();
    fail_att = 2; fail_first = 0; clear_mon();
    pulse_start(10'h13C, 0, 0);
    wait_done();
    check(starts == 3 && stops == 3, "R7 retried twice", starts, 3);
    check(gap_min >= 4, "R7 bus free gap", gap_min, 4);
    check(acked && !timeout, "R8 unbounded acked", {acked, timeout}, 2);
    check(b0 == 8'hF2 && b1 == 8'h3C, "R3 bytes addr 13C", {b0, b1}, 16'hF23C);
    check(per_min == 4 && per_max == 4, "R4 bit period div0", per_min, 4);
    check(dones == 1, "R7 no early done", dones, 1);
  endtask

  task automatic t_first_nack_timeout();
    fail_att = 100; fail_first = 1; clear_mon();
    pulse_start(10'h3E1, 1, 3);
    wait_done();
    check(starts == 3, "R8 limit three attempts", starts, 3);
    check(max_bytes == 1, "R6 second byte skipped", max_bytes, 1);
    check(b0 == 8'hF6, "R3 header addr 3E1", b0, 8'hF6);
    check(timeout && !acked, "R8 timeout flag", {acked, timeout}, 1);
    check(gap_min >= 8, "R7 gap div1", gap_min, 8);
    repeat (50) @(negedge clk);
    check(timeout == 1'b1, "R9 timeout held", timeout, 1);
  endtask

  task automatic t_limit_one_then_clear();
    fail_att = 100; fail_first = 0; clear_mon();
    pulse_start(10'h055, 0, 1);
    wait_done();
    check(starts == 1 && timeout, "R8 limit one", starts, 1);
    fail_att = 0; clear_mon();
    pulse_start(10'h055, 0, 1);
    @(negedge clk);
    check(!timeout && !acked, "R9 flags cleared on start", {acked, timeout}, 0);
    wait_done();
    check(acked && !timeout, "R9 new outcome", {acked, timeout}, 2);
  endtask

  task automatic t_stretch();
    fail_att = 0; fail_first = 0; stretch_en = 1; clear_mon();
    pulse_start(10'h0C3, 1, 0);
    wait_done();
    stretch_en = 0;
    check(b0 == 8'hF0 && b1 == 8'hC3, "R10 bytes under stretch", {b0, b1}, 16'hF0C3);
    check(acked && starts == 1, "R10 outcome under stretch", starts, 1);
    check(per_min > 8, "R10 bits slowed", per_min, 9);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_ack();
    t_second_nack_retry();
    t_first_nack_timeout();
    t_limit_one_then_clear();
    t_stretch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule